// File: doc/BRIEF.md
# Arithmetic Unit with Excess Word

This block is the data-path arithmetic unit of a small word-oriented processor. Each cycle it may accept one operation: a 5-bit operation code, a destination operand `b`, a source operand `a`, and the present contents of the excess register. The excess register is held outside the block. One clock later the block returns four things: the word to write back into the destination, the next excess word, a strobe that says whether the excess register should be written, and the number of processor cycles the operation is charged.

The excess word always has a defined meaning for the operation that writes it. It is one of the following:

- a single carry bit,
- an all-ones borrow mark,
- the high half of a double-width product,
- the fractional half of a fixed-point quotient,
- the bits that a shift pushed out of the word.

Operand fetch, memory traffic and conditional tests are done by the surrounding pipeline. The word width is the parameter `WIDTH`, which defaults to 16. Every output is registered, so the latency is exactly one clock.

Top module: `ex_alu`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `res_o`, `ex_o`, `ex_we_o` and `cost_o` are all zero.
- R2: `out_valid` equals `in_valid` of the previous clock. The outputs in that cycle are the results for the inputs sampled at that edge.
- R3: Code 0x02 (add) returns (b+a) mod 2^W. Code 0x1A (add with carry) returns (b+a+ex) mod 2^W. Both write an excess of 1 when the true sum reaches 2^W, and 0 otherwise.
- R4: Code 0x03 (subtract) returns (b−a) mod 2^W. Code 0x1B (subtract with excess) returns (b−a+ex) mod 2^W. Both write the upper W bits of the 2W-bit two's-complement result, which is all ones when the result is negative.
- R5: Code 0x04 (unsigned multiply) and code 0x05 (signed multiply) form the 2W-bit product. The low half is the result and the high half is written as excess.
- R6: Code 0x06 (unsigned divide) and code 0x07 (signed divide, rounding toward zero) form q = (b·2^W)/a in 2W bits. The result is q's upper half and the excess is q's lower half. When a is zero, both are zero.
- R7: Code 0x08 returns b mod a, unsigned. Code 0x09 returns the signed remainder, which carries the sign of b. Both return 0 when a is zero. Neither writes the excess.
- R8: Code 0x01 returns a. Codes 0x0A, 0x0B and 0x0C return b AND a, b OR a and b XOR a. None of these writes the excess.
- R9: Code 0x0D returns b shifted right logically by a. Code 0x0E returns b shifted right arithmetically by a. Both write the excess as the low W bits of (b·2^W) shifted right logically by a. Code 0x0F returns (b shifted left by a) mod 2^W and writes the bits that left the word, that is bits 2W−1..W of b·2^a. A shift amount of W or more yields 0, or all copies of the sign bit for code 0x0E.
- R10: `cost_o` is 1 for codes 0x01 and 0x0A–0x0F. It is 2 for codes 0x02–0x05. It is 3 for codes 0x06–0x09, 0x1A and 0x1B.
- R11: Any other code is unsupported: `res_o` returns b, `ex_we_o` is 0 and `cost_o` is 0.
- R12: Whenever `ex_we_o` is 0, `ex_o` equals the excess input of the same operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operation is presented this cycle |
| op_i | input | 5 | Operation code |
| b_i | input | WIDTH | Destination operand |
| a_i | input | WIDTH | Source operand or shift amount |
| ex_i | input | WIDTH | Current excess register contents |
| out_valid | output | 1 | Results below belong to the previous cycle's operation |
| res_o | output | WIDTH | Word to write back to the destination |
| ex_o | output | WIDTH | Next excess word |
| ex_we_o | output | 1 | The excess register should take `ex_o` |
| cost_o | output | 2 | Processor cycles charged for the operation |

## Verification
The bench uses a 4-bit configuration. It sweeps every pair of operands under all 32 codes, and for the two excess-consuming codes it also sweeps every excess value. This covers every corner named below.

- Division and remainder by zero: a design that divided anyway would return the divider's undefined output instead of zeros.
- The most-negative dividend over −1: a wrong design would sign-flip into the wrong half.
- Negative signed remainders: a design that took the sign from a would disagree in the low bits.
- Shift amounts of W and above: a design that used only the low bits of a would wrap.
- Add with carry where the sum passes 2·2^W: the excess must stay 1 rather than 2.
- Subtract with excess where the result is positive and above 2^W−1: the excess must be 1, not all ones.

// File: rtl/ex_alu_pkg.sv
package ex_alu_pkg;

   typedef enum logic [4:0] {
      OP_MOVE = 5'h01,
      OP_ADD  = 5'h02,
      OP_SUB  = 5'h03,
      OP_MULU = 5'h04,
      OP_MULS = 5'h05,
      OP_DIVU = 5'h06,
      OP_DIVS = 5'h07,
      OP_REMU = 5'h08,
      OP_REMS = 5'h09,
      OP_AND  = 5'h0A,
      OP_OR   = 5'h0B,
      OP_XOR  = 5'h0C,
      OP_SRL  = 5'h0D,
      OP_SRA  = 5'h0E,
      OP_SLL  = 5'h0F,
      OP_ADDC = 5'h1A,
      OP_SUBC = 5'h1B
   } op_e;

   typedef enum logic [1:0] {
      CL_NONE   = 2'd0,
      CL_ADDSUB = 2'd1,
      CL_MULDIV = 2'd2,
      CL_BITS   = 2'd3
   } op_class_e;

   localparam int COST_W = 2;

   function automatic op_class_e op_class(input logic [4:0] code);
      case (op_e'(code))
         OP_ADD, OP_SUB, OP_ADDC, OP_SUBC:                     return CL_ADDSUB;
         OP_MULU, OP_MULS, OP_DIVU, OP_DIVS, OP_REMU, OP_REMS: return CL_MULDIV;
         OP_MOVE, OP_AND, OP_OR, OP_XOR,
         OP_SRL, OP_SRA, OP_SLL:                               return CL_BITS;
         default:                                              return CL_NONE;
      endcase
   endfunction

   function automatic logic [COST_W-1:0] op_cost(input logic [4:0] code);
      case (op_e'(code))
         OP_MOVE, OP_AND, OP_OR, OP_XOR, OP_SRL, OP_SRA, OP_SLL: return 2'd1;
         OP_ADD, OP_SUB, OP_MULU, OP_MULS:                       return 2'd2;
         OP_DIVU, OP_DIVS, OP_REMU, OP_REMS, OP_ADDC, OP_SUBC:   return 2'd3;
         default:                                                return 2'd0;
      endcase
   endfunction

   function automatic logic op_writes_ex(input logic [4:0] code);
      case (op_e'(code))
         OP_ADD, OP_SUB, OP_MULU, OP_MULS, OP_DIVU, OP_DIVS,
         OP_SRL, OP_SRA, OP_SLL, OP_ADDC, OP_SUBC:               return 1'b1;
         default:                                                return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/ex_alu_addsub.sv
module ex_alu_addsub
   import ex_alu_pkg::*;
#(
   parameter int W = 16
) (
   input  logic [4:0]   op,
   input  logic [W-1:0] b,
   input  logic [W-1:0] a,
   input  logic [W-1:0] ex,
   output logic [W-1:0] res,
   output logic [W-1:0] ex_new
);

   localparam int W2 = 2 * W;

   logic [W:0]    sum_plain;
   logic [W+1:0]  sum_carry;
   logic [W2-1:0] dif_plain;
   logic [W2-1:0] dif_carry;

   assign sum_plain = {1'b0, b} + {1'b0, a};
   assign sum_carry = {2'b00, b} + {2'b00, a} + {2'b00, ex};
   assign dif_plain = {{W{1'b0}}, b} - {{W{1'b0}}, a};
   assign dif_carry = {{W{1'b0}}, b} - {{W{1'b0}}, a} + {{W{1'b0}}, ex};

   always_comb begin
      res    = '0;
      ex_new = '0;
      case (op_e'(op))
         OP_ADD: begin
            res    = sum_plain[W-1:0];
            ex_new = {{(W-1){1'b0}}, sum_plain[W]};
         end
         OP_ADDC: begin
            res    = sum_carry[W-1:0];
            ex_new = {{(W-1){1'b0}}, |sum_carry[W+1:W]};
         end
         OP_SUB: begin
            res    = dif_plain[W-1:0];
            ex_new = dif_plain[W2-1:W];
         end
         OP_SUBC: begin
            res    = dif_carry[W-1:0];
            ex_new = dif_carry[W2-1:W];
         end
         default: begin
            res    = '0;
            ex_new = '0;
         end
      endcase
   end

endmodule

// File: rtl/ex_alu_muldiv.sv
module ex_alu_muldiv
   import ex_alu_pkg::*;
#(
   parameter int W = 16
) (
   input  logic [4:0]   op,
   input  logic [W-1:0] b,
   input  logic [W-1:0] a,
   output logic [W-1:0] res,
   output logic [W-1:0] ex_new
);

   localparam int W2 = 2 * W;
   localparam int DW = 2 * W + 2;
   localparam int RW = W + 1;

   logic              a_zero;
   logic [W-1:0]      a_safe;
   logic [W2-1:0]     prod_u;
   logic signed [W2-1:0] prod_s;
   logic [W2-1:0]     quo_u;
   logic signed [DW-1:0] quo_s;
   logic [W-1:0]      rem_u;
   logic signed [RW-1:0] rem_s;
   logic              unused_hi;

   assign a_zero = (a == '0);
   assign a_safe = a_zero ? {{(W-1){1'b0}}, 1'b1} : a;

   assign prod_u = {{W{1'b0}}, b} * {{W{1'b0}}, a};
   assign prod_s = $signed({{W{b[W-1]}}, b}) * $signed({{W{a[W-1]}}, a});
   assign quo_u  = {b, {W{1'b0}}} / {{W{1'b0}}, a_safe};
   assign quo_s  = $signed({{2{b[W-1]}}, b, {W{1'b0}}})
                 / $signed({{(W+2){a_safe[W-1]}}, a_safe});
   assign rem_u  = b % a_safe;
   assign rem_s  = $signed({b[W-1], b}) % $signed({a_safe[W-1], a_safe});

   assign unused_hi = ^{quo_s[DW-1:W2], rem_s[RW-1]};

   always_comb begin
      res    = '0;
      ex_new = '0;
      case (op_e'(op))
         OP_MULU: begin
            res    = prod_u[W-1:0];
            ex_new = prod_u[W2-1:W];
         end
         OP_MULS: begin
            res    = prod_s[W-1:0];
            ex_new = prod_s[W2-1:W];
         end
         OP_DIVU: begin
            res    = a_zero ? '0 : quo_u[W2-1:W];
            ex_new = a_zero ? '0 : quo_u[W-1:0];
         end
         OP_DIVS: begin
            res    = a_zero ? '0 : quo_s[W2-1:W];
            ex_new = a_zero ? '0 : quo_s[W-1:0];
         end
         OP_REMU: res = a_zero ? '0 : rem_u;
         OP_REMS: res = a_zero ? '0 : rem_s[W-1:0];
         default: begin
            res    = '0;
            ex_new = '0;
         end
      endcase
   end

endmodule

// File: rtl/ex_alu_bitshift.sv
module ex_alu_bitshift
   import ex_alu_pkg::*;
#(
   parameter int W = 16
) (
   input  logic [4:0]   op,
   input  logic [W-1:0] b,
   input  logic [W-1:0] a,
   output logic [W-1:0] res,
   output logic [W-1:0] ex_new
);

   localparam int W2 = 2 * W;

   logic [W2-1:0] right_wide;
   logic [W2-1:0] left_wide;
   logic [W-1:0]  right_arith;

   assign right_wide  = {b, {W{1'b0}}} >> a;
   assign left_wide   = {{W{1'b0}}, b} << a;
   assign right_arith = $signed(b) >>> a;

   always_comb begin
      res    = '0;
      ex_new = '0;
      case (op_e'(op))
         OP_MOVE: res = a;
         OP_AND:  res = b & a;
         OP_OR:   res = b | a;
         OP_XOR:  res = b ^ a;
         OP_SRL: begin
            res    = right_wide[W2-1:W];
            ex_new = right_wide[W-1:0];
         end
         OP_SRA: begin
            res    = right_arith;
            ex_new = right_wide[W-1:0];
         end
         OP_SLL: begin
            res    = left_wide[W-1:0];
            ex_new = left_wide[W2-1:W];
         end
         default: begin
            res    = '0;
            ex_new = '0;
         end
      endcase
   end

endmodule

// File: rtl/ex_alu.sv
module ex_alu
   import ex_alu_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [4:0]       op_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] ex_i,
   output logic             out_valid,
   output logic [WIDTH-1:0] res_o,
   output logic [WIDTH-1:0] ex_o,
   output logic             ex_we_o,
   output logic [1:0]       cost_o
);

   generate
      if (WIDTH < 2 || WIDTH > 32) begin : g_bad_width
         $error("ex_alu: WIDTH must lie in 2..32");
      end
   endgenerate

   localparam int NUNIT = 3;

   logic [WIDTH-1:0]  unit_res [NUNIT];
   logic [WIDTH-1:0]  unit_ex  [NUNIT];
   op_class_e         cls;
   logic              we_nxt;
   logic [WIDTH-1:0]  res_nxt;
   logic [WIDTH-1:0]  ex_nxt;
   logic [COST_W-1:0] cost_nxt;

   ex_alu_addsub #(.W(WIDTH)) u_addsub (
      .op(op_i), .b(b_i), .a(a_i), .ex(ex_i),
      .res(unit_res[0]), .ex_new(unit_ex[0])
   );

   ex_alu_muldiv #(.W(WIDTH)) u_muldiv (
      .op(op_i), .b(b_i), .a(a_i),
      .res(unit_res[1]), .ex_new(unit_ex[1])
   );

   ex_alu_bitshift #(.W(WIDTH)) u_bits (
      .op(op_i), .b(b_i), .a(a_i),
      .res(unit_res[2]), .ex_new(unit_ex[2])
   );

   assign cls      = op_class(op_i);
   assign we_nxt   = op_writes_ex(op_i);
   assign cost_nxt = op_cost(op_i);

   always_comb begin
      case (cls)
         CL_ADDSUB: begin res_nxt = unit_res[0]; ex_nxt = unit_ex[0]; end
         CL_MULDIV: begin res_nxt = unit_res[1]; ex_nxt = unit_ex[1]; end
         CL_BITS:   begin res_nxt = unit_res[2]; ex_nxt = unit_ex[2]; end
         default:   begin res_nxt = b_i;         ex_nxt = ex_i;       end
      endcase
      if (!we_nxt) ex_nxt = ex_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         res_o     <= '0;
         ex_o      <= '0;
         ex_we_o   <= 1'b0;
         cost_o    <= '0;
      end else begin
         out_valid <= in_valid;
         res_o     <= res_nxt;
         ex_o      <= ex_nxt;
         ex_we_o   <= we_nxt;
         cost_o    <= cost_nxt;
      end
   end

endmodule

// File: rtl/ex_alu_chk.sv
module ex_alu_chk #(
   parameter int WIDTH = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [4:0]       op_i,
   input logic [WIDTH-1:0] b_i,
   input logic [WIDTH-1:0] a_i,
   input logic [WIDTH-1:0] ex_i,
   input logic             out_valid,
   input logic [WIDTH-1:0] res_o,
   input logic [WIDTH-1:0] ex_o,
   input logic             ex_we_o,
   input logic [1:0]       cost_o
);

   logic unsup;
   assign unsup = (op_i == 5'h00) || (op_i >= 5'h10 && op_i <= 5'h19) || (op_i >= 5'h1C);

   p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   p_carry_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && op_i == 5'h02 |=> ex_o[WIDTH-1:1] == '0 && ex_we_o);

   p_borrow_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && op_i == 5'h03 && a_i > b_i |=> ex_o == '1 && ex_we_o);

   p_div_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && (op_i == 5'h06 || op_i == 5'h07) && a_i == '0
      |=> res_o == '0 && ex_o == '0);

   p_rem_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && (op_i == 5'h08 || op_i == 5'h09)
      |=> !ex_we_o && ex_o == $past(ex_i) && cost_o == 2'd3);

   p_unsup_pass_r11: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && unsup
      |=> res_o == $past(b_i) && !ex_we_o && cost_o == 2'd0);

   p_ex_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> ex_we_o || ex_o == $past(ex_i));

   p_cost_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && ex_we_o |-> cost_o != 2'd0);

   p_move_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && op_i == 5'h01 |=> res_o == $past(a_i) && !ex_we_o);

endmodule

bind ex_alu ex_alu_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/ex_alu_test.sv
module ex_alu_test;

   localparam int W = 4;
   localparam int M = (1 << W) - 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [4:0]   op_i = '0;
   logic [W-1:0] b_i = '0;
   logic [W-1:0] a_i = '0;
   logic [W-1:0] ex_i = '0;
   logic         out_valid;
   logic [W-1:0] res_o;
   logic [W-1:0] ex_o;
   logic         ex_we_o;
   logic [1:0]   cost_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   ex_alu #(.WIDTH(W)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_i(op_i),
      .b_i(b_i), .a_i(a_i), .ex_i(ex_i), .out_valid(out_valid),
      .res_o(res_o), .ex_o(ex_o), .ex_we_o(ex_we_o), .cost_o(cost_o)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic string req_of(input int op);
      case (op)
         2, 26:     return "R3";
         3, 27:     return "R4";
         4, 5:      return "R5";
         6, 7:      return "R6";
         8, 9:      return "R7";
         1, 10, 11, 12: return "R8";
         13, 14, 15:    return "R9";
         default:   return "R11";
      endcase
   endfunction

   function automatic int sx(input int v);
      return (v > (M >> 1)) ? v - (M + 1) : v;
   endfunction

   task automatic model(input int op, input int b, input int a, input int ex,
                        output int r, output int e, output int we, output int c);
      int s, sb, sa;
      sb = sx(b);
      sa = sx(a);
      r = b; e = ex; we = 0; c = 0;
      case (op)
         1:  begin r = a; c = 1; end
         2:  begin s = b + a; r = s & M; e = s >> W; we = 1; c = 2; end
         3:  begin s = b - a; r = s & M; e = (s < 0) ? M : 0; we = 1; c = 2; end
         4:  begin s = b * a; r = s & M; e = (s >> W) & M; we = 1; c = 2; end
         5:  begin s = sb * sa; r = s & M; e = (s >>> W) & M; we = 1; c = 2; end
         6:  begin
                we = 1; c = 3;
                if (a == 0) begin r = 0; e = 0; end
                else begin s = (b << W) / a; r = (s >> W) & M; e = s & M; end
             end
         7:  begin
                we = 1; c = 3;
                if (a == 0) begin r = 0; e = 0; end
                else begin s = (sb * (M + 1)) / sa; r = (s >>> W) & M; e = s & M; end
             end
         8:  begin c = 3; r = (a == 0) ? 0 : b % a; end
         9:  begin c = 3; r = (a == 0) ? 0 : ((sb % sa) & M); end
         10: begin r = b & a; c = 1; end
         11: begin r = b | a; c = 1; end
         12: begin r = b ^ a; c = 1; end
         13: begin r = (a >= W) ? 0 : (b >> a); e = ((b << W) >> a) & M; we = 1; c = 1; end
         14: begin r = (sb >>> a) & M; e = ((b << W) >> a) & M; we = 1; c = 1; end
         15: begin r = (b << a) & M; e = ((b << a) >> W) & M; we = 1; c = 1; end
         26: begin s = b + a + ex; r = s & M; e = ((s >> W) != 0) ? 1 : 0; we = 1; c = 3; end
         27: begin s = b - a + ex; r = s & M; e = (s >>> W) & M; we = 1; c = 3; end
         default: ;
      endcase
   endtask

   initial begin
      int r, e, we, c, nex;
      repeat (3) @(negedge clk);
      check("R1", "out_valid in reset", int'(out_valid), 0);
      check("R1", "res in reset", int'(res_o), 0);
      check("R1", "ex in reset", int'(ex_o), 0);
      check("R1", "ex_we in reset", int'(ex_we_o), 0);
      check("R1", "cost in reset", int'(cost_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R2", "out_valid idle", int'(out_valid), 0);
      in_valid = 1'b1;
      for (int op = 0; op < 32; op++) begin
         nex = (op == 26 || op == 27) ? M + 1 : 1;
         for (int b = 0; b <= M; b++) begin
            for (int a = 0; a <= M; a++) begin
               for (int k = 0; k < nex; k++) begin
                  int exv;
                  exv = (nex == 1) ? ((b ^ ~a) & M) : k;
                  op_i = 5'(op);
                  b_i  = W'(b);
                  a_i  = W'(a);
                  ex_i = W'(exv);
                  @(negedge clk);
                  model(op, b, a, exv, r, e, we, c);
                  check("R2", "out_valid busy", int'(out_valid), 1);
                  check(req_of(op), $sformatf("res op=%0d b=%0d a=%0d ex=%0d", op, b, a, exv), int'(res_o), r);
                  check(req_of(op), $sformatf("ex_we op=%0d", op), int'(ex_we_o), we);
                  check((we != 0) ? req_of(op) : "R12",
                        $sformatf("ex op=%0d b=%0d a=%0d ex=%0d", op, b, a, exv), int'(ex_o), e);
                  check("R10", $sformatf("cost op=%0d", op), int'(cost_o), c);
               end
            end
         end
      end
      in_valid = 1'b0;
      @(negedge clk);
      check("R2", "out_valid after stop", int'(out_valid), 0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (60000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule